// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block takes one or two SDRAM chip-select regions from the end of reset to the point where a normal-mode controller can use them. On a start pulse it captures its configuration and raises clock-enable. For each selected region it then issues, in a fixed order, a precharge-all, a burst of auto-refresh commands and a load-mode-register command, with long waits counted in microseconds between the steps. It finishes each region by handing a refresh period to a separate refresh timer.

The microsecond waits come from a clocks-per-microsecond parameter, so the same logic serves any controller clock. The CAS latency, the auto-refresh spacing and the refresh count are inputs sampled when the start pulse is accepted. A controller-enable output stays low until the last region is done, and then it rises together with the done flag. A target index that no chip-select line exists for is refused with an error flag, and no command is issued.

Top module: `sdram_pwrup_seq`

## Requirements
- R1: For each region the command order is: clock-enable window, precharge-all, auto-refresh burst, load-mode, then a one-cycle normal-mode hand-over cycle.
- R2: Precharge-all is issued exactly PWR_WAIT_US × CLK_PER_US cycles after the first cycle of the clock-enable window.
- R3: The first auto-refresh, the load-mode command and the hand-over cycle each follow the command before them after STEP_WAIT_US × CLK_PER_US NOP cycles.
- R4: The burst holds AREF_FIELD+1 auto-refresh commands (8 by default). Commands start t_rc cycles apart, and they are back to back when t_rc is 0 or 1.
- R5: During load-mode the address bus carries the CAS latency in bits [6:4] and zero in every other bit, so bits [2:0] hold burst code 0. The bank address is 0.
- R6: Encodings as (CS#, RAS#, CAS#, WE#): NOP = 0111, precharge-all = 0010 with address bit 10 high, auto-refresh = 0001, load-mode = 0000. When idle every CS# is high and RAS#, CAS# and WE# are high.
- R7: In two-region mode the first target is set up completely before the second. Only the active target's CS# is ever low, and clock-enable never falls once it has risen.
- R8: ctrl_en and done fall on an accepted start, stay low while busy, and both rise in the cycle after the last hand-over cycle.
- R9: In each hand-over cycle ref_load pulses and ref_period equals twice the captured refresh count. A refresh count of 0 selects 8196.
- R10: A start whose first target, or whose second target in two-region mode, is 2 or more sets err, keeps busy low, leaves done and ctrl_en low and issues no command. A later valid start clears err.
- R11: A start pulse that arrives while busy is ignored, and so are changes to the configuration inputs while busy.
- R12: After reset, clock-enable, busy, done, ctrl_en, err, ref_load and ref_period are 0, and the command pins are idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Start pulse; accepted only when idle |
| two_banks | input | 1 | 1 = set up both targets in turn, 0 = first target only |
| tgt_first | input | TGT_W | Chip-select index of the first region |
| tgt_second | input | TGT_W | Chip-select index of the second region |
| cas_lat | input | 3 | CAS latency placed in the mode word |
| t_rc | input | TRC_W | Cycles between auto-refresh commands |
| ref_count | input | REF_W | Refresh count; 0 selects the default |
| cke | output | 1 | SDRAM clock enable |
| cs_n | output | NUM_CS | Active-low chip selects |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | BA_W | Bank address |
| addr | output | ADDR_W | Address bus |
| ref_load | output | 1 | Pulse: load ref_period into the refresh timer |
| ref_period | output | REF_W+1 | Refresh period (count shifted left by one) |
| ctrl_en | output | 1 | Controller enable, high once all regions are set up |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Sequence completed |
| err | output | 1 | Last start refused for an invalid target |

## Verification
The assertions assume that start is a synchronous input and that the target indices are only acted on when start is accepted while idle. They therefore check pin encodings and flag relations only in the cycles the sequencer drives, and make no claim about inputs between runs. The stimulus changes inputs only at the falling clock edge. It raises start mid-sequence, together with different configuration values, to exercise the ignore rule. It reaches the error path with targets 2 and 3, then runs a valid sequence to show the error clearing.

// File: rtl/sdram_pwrup_pkg.sv
// Shared types for the SDRAM power-up sequencer.
// Assumes: a single controller clock domain; encodings are internal only.
package sdram_pwrup_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CKE_WAIT,
        ST_PRE,
        ST_PRE_WAIT,
        ST_AREF,
        ST_AREF_GAP,
        ST_AREF_WAIT,
        ST_MRS,
        ST_MRS_WAIT,
        ST_HANDOVER
    } pwr_state_t;

    typedef enum logic [2:0] {
        CMD_DESEL,
        CMD_NOP,
        CMD_PRE_ALL,
        CMD_AREF,
        CMD_MRS
    } sdr_cmd_t;

    // Mode word layout: burst code in the low bits, CAS latency above it.
    localparam int MW_CAS_LSB  = 4;
    localparam int AUTO_PRE_BIT = 10;

endpackage

// File: rtl/sdram_pwrup_timer.sv
// Down-counter for the wait windows.
// Assumes: load_val is the window length minus one; zero marks the last cycle.
module sdram_pwrup_timer #(
    parameter int TMR_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [TMR_W-1:0] load_val,
    output logic             zero
);
    logic [TMR_W-1:0] cnt_q;

    // Load a new window or count the current one down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/sdram_pwrup_ctrl.sv
// Step sequencer: owns the state, captured configuration and status flags.
// Assumes: the timer's zero output refers to the window loaded on entry to
// the current wait state; configuration is sampled only on an accepted start.
module sdram_pwrup_ctrl
    import sdram_pwrup_pkg::*;
#(
    parameter int CLK_PER_US   = 100,
    parameter int PWR_WAIT_US  = 200,
    parameter int STEP_WAIT_US = 100,
    parameter int AREF_FIELD   = 7,
    parameter int NUM_CS       = 2,
    parameter int TGT_W        = 2,
    parameter int TRC_W        = 4,
    parameter int REF_W        = 14,
    parameter int DEF_REF_CNT  = 8196,
    parameter int TMR_W        = 16,
    parameter int CS_IDX_W     = 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic                two_banks,
    input  logic [TGT_W-1:0]    tgt_first,
    input  logic [TGT_W-1:0]    tgt_second,
    input  logic [2:0]          cas_lat,
    input  logic [TRC_W-1:0]    t_rc,
    input  logic [REF_W-1:0]    ref_count,
    input  logic                tmr_zero,
    output logic                tmr_load,
    output logic [TMR_W-1:0]    tmr_val,
    output sdr_cmd_t            cmd,
    output logic [CS_IDX_W-1:0] tgt_sel,
    output logic [2:0]          cas_sel,
    output logic                cke,
    output logic                ref_load,
    output logic [REF_W:0]      ref_period,
    output logic                ctrl_en,
    output logic                busy,
    output logic                done,
    output logic                err
);
    localparam int WAIT_LONG  = PWR_WAIT_US * CLK_PER_US;
    localparam int WAIT_SHORT = STEP_WAIT_US * CLK_PER_US;
    localparam int AREF_W     = (AREF_FIELD > 0) ? $clog2(AREF_FIELD + 1) : 1;
    localparam logic [TMR_W-1:0] LONG_LOAD  = TMR_W'(WAIT_LONG - 1);
    localparam logic [TMR_W-1:0] SHORT_LOAD = TMR_W'(WAIT_SHORT - 1);

    pwr_state_t          state_q, state_d;
    logic                bank_q;
    logic [AREF_W-1:0]   aref_q;
    logic                two_q;
    logic [CS_IDX_W-1:0] tgt_q [2];
    logic [TRC_W-1:0]    trc_q;
    logic [2:0]          cas_q;
    logic [REF_W-1:0]    ref_q;
    logic                cke_q, done_q, en_q, err_q;
    logic                accept, bad_tgt, last_aref, last_bank;

    // A target index beyond the chip-select lines refuses the start.
    assign bad_tgt   = (int'(tgt_first) >= NUM_CS) ||
                       (two_banks && (int'(tgt_second) >= NUM_CS));
    assign accept    = start && (state_q == ST_IDLE);
    assign last_aref = (aref_q == AREF_W'(AREF_FIELD));
    assign last_bank = (bank_q == two_q);

    // Next-state and timer-load decisions for the fixed step order.
    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (state_q)
            ST_IDLE: if (accept && !bad_tgt) begin
                state_d = ST_CKE_WAIT; tmr_load = 1'b1; tmr_val = LONG_LOAD;
            end
            ST_CKE_WAIT: if (tmr_zero) state_d = ST_PRE;
            ST_PRE: begin
                state_d = ST_PRE_WAIT; tmr_load = 1'b1; tmr_val = SHORT_LOAD;
            end
            ST_PRE_WAIT: if (tmr_zero) state_d = ST_AREF;
            ST_AREF: begin
                if (last_aref) begin
                    state_d = ST_AREF_WAIT; tmr_load = 1'b1; tmr_val = SHORT_LOAD;
                end else if (trc_q > TRC_W'(1)) begin
                    state_d  = ST_AREF_GAP;
                    tmr_load = 1'b1;
                    tmr_val  = TMR_W'(trc_q) - TMR_W'(2);
                end
            end
            ST_AREF_GAP:  if (tmr_zero) state_d = ST_AREF;
            ST_AREF_WAIT: if (tmr_zero) state_d = ST_MRS;
            ST_MRS: begin
                state_d = ST_MRS_WAIT; tmr_load = 1'b1; tmr_val = SHORT_LOAD;
            end
            ST_MRS_WAIT: if (tmr_zero) state_d = ST_HANDOVER;
            ST_HANDOVER: begin
                if (last_bank) begin
                    state_d = ST_IDLE;
                end else begin
                    state_d = ST_CKE_WAIT; tmr_load = 1'b1; tmr_val = LONG_LOAD;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State, captured configuration, burst counter and status flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            bank_q   <= 1'b0;
            aref_q   <= '0;
            two_q    <= 1'b0;
            tgt_q[0] <= '0;
            tgt_q[1] <= '0;
            trc_q    <= '0;
            cas_q    <= '0;
            ref_q    <= '0;
            cke_q    <= 1'b0;
            done_q   <= 1'b0;
            en_q     <= 1'b0;
            err_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                done_q <= 1'b0;
                en_q   <= 1'b0;
                err_q  <= bad_tgt;
                if (!bad_tgt) begin
                    cke_q    <= 1'b1;
                    bank_q   <= 1'b0;
                    two_q    <= two_banks;
                    tgt_q[0] <= tgt_first[CS_IDX_W-1:0];
                    tgt_q[1] <= tgt_second[CS_IDX_W-1:0];
                    trc_q    <= t_rc;
                    cas_q    <= cas_lat;
                    ref_q    <= (ref_count == '0) ? REF_W'(DEF_REF_CNT) : ref_count;
                end
            end
            if (state_q == ST_PRE) begin
                aref_q <= '0;
            end else if (state_q == ST_AREF && !last_aref) begin
                aref_q <= aref_q + 1'b1;
            end
            if (state_q == ST_HANDOVER) begin
                if (last_bank) begin
                    done_q <= 1'b1;
                    en_q   <= 1'b1;
                end else begin
                    bank_q <= 1'b1;
                end
            end
        end
    end

    // Map the current step onto the command the pins should carry.
    always_comb begin
        unique case (state_q)
            ST_IDLE: cmd = CMD_DESEL;
            ST_PRE:  cmd = CMD_PRE_ALL;
            ST_AREF: cmd = CMD_AREF;
            ST_MRS:  cmd = CMD_MRS;
            default: cmd = CMD_NOP;
        endcase
    end

    assign tgt_sel    = tgt_q[bank_q];
    assign cas_sel    = cas_q;
    assign cke        = cke_q;
    assign busy       = (state_q != ST_IDLE);
    assign ref_load   = (state_q == ST_HANDOVER);
    assign ref_period = {ref_q, 1'b0};
    assign ctrl_en    = en_q;
    assign done       = done_q;
    assign err        = err_q;
endmodule

// File: rtl/sdram_pwrup_cmd_enc.sv
// Turns an abstract command into SDRAM command pins.
// Assumes: tgt is a valid chip-select index whenever cmd is not DESEL.
module sdram_pwrup_cmd_enc
    import sdram_pwrup_pkg::*;
#(
    parameter int NUM_CS   = 2,
    parameter int CS_IDX_W = 1,
    parameter int BA_W     = 2,
    parameter int ADDR_W   = 13
) (
    input  sdr_cmd_t            cmd,
    input  logic [CS_IDX_W-1:0] tgt,
    input  logic [2:0]          cas_lat,
    output logic [NUM_CS-1:0]   cs_n,
    output logic                ras_n,
    output logic                cas_n,
    output logic                we_n,
    output logic [BA_W-1:0]     ba,
    output logic [ADDR_W-1:0]   addr
);
    // One active-low select per chip-select line.
    for (genvar g = 0; g < NUM_CS; g++) begin : g_cs
        assign cs_n[g] = !((cmd != CMD_DESEL) && (tgt == CS_IDX_W'(g)));
    end

    // Strobe pattern and address content for each command.
    always_comb begin
        ras_n = 1'b1;
        cas_n = 1'b1;
        we_n  = 1'b1;
        ba    = '0;
        addr  = '0;
        unique case (cmd)
            CMD_PRE_ALL: begin
                ras_n = 1'b0;
                we_n  = 1'b0;
                addr[AUTO_PRE_BIT] = 1'b1;
            end
            CMD_AREF: begin
                ras_n = 1'b0;
                cas_n = 1'b0;
            end
            CMD_MRS: begin
                ras_n = 1'b0;
                cas_n = 1'b0;
                we_n  = 1'b0;
                addr[MW_CAS_LSB +: 3] = cas_lat;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/sdram_pwrup_seq.sv
// Top of the SDRAM power-up sequencer: sequencer, wait timer, pin encoder.
// Assumes: one clock; start sampled only while idle; NUM_CS <= 2**TGT_W.
module sdram_pwrup_seq
    import sdram_pwrup_pkg::*;
#(
    parameter int CLK_PER_US   = 100,
    parameter int PWR_WAIT_US  = 200,
    parameter int STEP_WAIT_US = 100,
    parameter int AREF_FIELD   = 7,
    parameter int NUM_CS       = 2,
    parameter int TGT_W        = 2,
    parameter int TRC_W        = 4,
    parameter int REF_W        = 14,
    parameter int DEF_REF_CNT  = 8196,
    parameter int BA_W         = 2,
    parameter int ADDR_W       = 13
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               two_banks,
    input  logic [TGT_W-1:0]   tgt_first,
    input  logic [TGT_W-1:0]   tgt_second,
    input  logic [2:0]         cas_lat,
    input  logic [TRC_W-1:0]   t_rc,
    input  logic [REF_W-1:0]   ref_count,
    output logic               cke,
    output logic [NUM_CS-1:0]  cs_n,
    output logic               ras_n,
    output logic               cas_n,
    output logic               we_n,
    output logic [BA_W-1:0]    ba,
    output logic [ADDR_W-1:0]  addr,
    output logic               ref_load,
    output logic [REF_W:0]     ref_period,
    output logic               ctrl_en,
    output logic               busy,
    output logic               done,
    output logic               err
);
    localparam int LONGEST  = PWR_WAIT_US * CLK_PER_US;
    localparam int TMR_RAW  = $clog2(LONGEST + 1);
    localparam int TMR_W    = (TMR_RAW > TRC_W) ? TMR_RAW : TRC_W;
    localparam int CS_IDX_W = (NUM_CS > 1) ? $clog2(NUM_CS) : 1;

    logic                tmr_load, tmr_zero;
    logic [TMR_W-1:0]    tmr_val;
    sdr_cmd_t            cmd;
    logic [CS_IDX_W-1:0] tgt_sel;
    logic [2:0]          cas_sel;

    sdram_pwrup_ctrl #(
        .CLK_PER_US(CLK_PER_US), .PWR_WAIT_US(PWR_WAIT_US),
        .STEP_WAIT_US(STEP_WAIT_US), .AREF_FIELD(AREF_FIELD),
        .NUM_CS(NUM_CS), .TGT_W(TGT_W), .TRC_W(TRC_W), .REF_W(REF_W),
        .DEF_REF_CNT(DEF_REF_CNT), .TMR_W(TMR_W), .CS_IDX_W(CS_IDX_W)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .two_banks(two_banks),
        .tgt_first(tgt_first), .tgt_second(tgt_second), .cas_lat(cas_lat),
        .t_rc(t_rc), .ref_count(ref_count), .tmr_zero(tmr_zero),
        .tmr_load(tmr_load), .tmr_val(tmr_val), .cmd(cmd), .tgt_sel(tgt_sel),
        .cas_sel(cas_sel), .cke(cke), .ref_load(ref_load),
        .ref_period(ref_period), .ctrl_en(ctrl_en), .busy(busy),
        .done(done), .err(err)
    );

    sdram_pwrup_timer #(.TMR_W(TMR_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val),
        .zero(tmr_zero)
    );

    sdram_pwrup_cmd_enc #(
        .NUM_CS(NUM_CS), .CS_IDX_W(CS_IDX_W), .BA_W(BA_W), .ADDR_W(ADDR_W)
    ) u_enc (
        .cmd(cmd), .tgt(tgt_sel), .cas_lat(cas_sel), .cs_n(cs_n),
        .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr)
    );
endmodule

// File: rtl/sdram_pwrup_seq_chk.sv
// Property checker for the power-up sequencer, bound to the top module.
// Assumes: synchronous active-low reset; observes ports only.
module sdram_pwrup_seq_chk #(
    parameter int NUM_CS = 2,
    parameter int BA_W   = 2,
    parameter int ADDR_W = 13,
    parameter int REF_W  = 14
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cke,
    input logic [NUM_CS-1:0] cs_n,
    input logic              ras_n,
    input logic              cas_n,
    input logic              we_n,
    input logic [BA_W-1:0]   ba,
    input logic [ADDR_W-1:0] addr,
    input logic              ref_load,
    input logic [REF_W:0]    ref_period,
    input logic              ctrl_en,
    input logic              busy,
    input logic              done,
    input logic              err
);
    logic selected, is_pre, is_mrs;
    assign selected = !(&cs_n);
    assign is_pre   = selected && !ras_n && cas_n && !we_n;
    assign is_mrs   = selected && !ras_n && !cas_n && !we_n;

    assert_one_cs_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~cs_n));
    assert_cke_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !$fell(cke));
    assert_pre_a10_R6: assert property (@(posedge clk) disable iff (!rst_n)
        is_pre |-> addr[10]);
    assert_idle_pins_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!selected && ras_n && cas_n && we_n));
    assert_mrs_word_R5: assert property (@(posedge clk) disable iff (!rst_n)
        is_mrs |-> (addr[3:0] == 4'd0 && ba == '0));
    assert_en_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (!ctrl_en && !done));
    assert_finish_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (done && ctrl_en));
    assert_ref_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ref_load |-> (busy && !ref_period[0] && ref_period != '0));
    assert_err_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (!busy && !done && !ctrl_en));
    assert_busy_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !ref_load) |=> busy);
endmodule

bind sdram_pwrup_seq sdram_pwrup_seq_chk #(
    .NUM_CS(NUM_CS), .BA_W(BA_W), .ADDR_W(ADDR_W), .REF_W(REF_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr), .ref_load(ref_load),
    .ref_period(ref_period), .ctrl_en(ctrl_en), .busy(busy), .done(done),
    .err(err)
);

// File: tb/sdram_pwrup_seq_bench.sv
// Bench: a queue of expected per-cycle pin states is built from the
// requirements when a start is issued, and compared on every falling edge.
module sdram_pwrup_seq_bench;
    localparam int CLK_PERIOD = 10;
    localparam int CPU  = 2;
    localparam int PWU  = 200;
    localparam int STU  = 100;
    localparam int NREF = 8;
    localparam int W_L  = PWU * CPU;
    localparam int W_S  = STU * CPU;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic two_banks = 1'b0;
    logic [1:0] tgt_first = '0, tgt_second = '0;
    logic [2:0] cas_lat = '0;
    logic [3:0] t_rc = '0;
    logic [13:0] ref_count = '0;
    logic cke, ras_n, cas_n, we_n, ref_load, ctrl_en, busy, done, err;
    logic [1:0] cs_n, ba;
    logic [12:0] addr;
    logic [14:0] ref_period;

    always #(CLK_PERIOD/2) clk = ~clk;

    sdram_pwrup_seq #(.CLK_PER_US(CPU), .PWR_WAIT_US(PWU), .STEP_WAIT_US(STU))
    u_sdram_pwrup_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .two_banks(two_banks),
        .tgt_first(tgt_first), .tgt_second(tgt_second), .cas_lat(cas_lat),
        .t_rc(t_rc), .ref_count(ref_count), .cke(cke), .cs_n(cs_n),
        .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr),
        .ref_load(ref_load), .ref_period(ref_period), .ctrl_en(ctrl_en),
        .busy(busy), .done(done), .err(err)
    );

    typedef struct packed {
        logic cke; logic [1:0] cs_n; logic ras_n, cas_n, we_n;
        logic [1:0] ba; logic [12:0] addr; logic ref_load;
        logic [14:0] ref_period; logic busy, done, en, err;
    } rec_t;

    rec_t  exp_q[$];
    string tag_q[$];
    rec_t  idle_r;
    string idle_tag = "R12";
    int n_chk = 0, n_fail = 0, aref_seen = 0;
    logic [12:0] mrs_addr = '0;
    bit finished = 0;

    function automatic rec_t observed();
        return '{cke, cs_n, ras_n, cas_n, we_n, ba, addr, ref_load,
                 ref_period, busy, done, ctrl_en, err};
    endfunction

    task automatic check(input bit ok, input string tag,
                         input logic [63:0] act, input logic [63:0] expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, expv);
        end
    endtask

    task automatic tick();
        rec_t a, e;
        string t;
        @(negedge clk);
        a = observed();
        if (!a.cs_n[0] || !a.cs_n[1]) begin
            if (!a.ras_n && !a.cas_n && a.we_n) aref_seen++;
            if (!a.ras_n && !a.cas_n && !a.we_n) mrs_addr = a.addr;
        end
        if (exp_q.size() > 0) begin
            e = exp_q.pop_front();
            t = tag_q.pop_front();
        end else begin
            e = idle_r;
            t = idle_tag;
        end
        n_chk++;
        if (a !== e) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", t, a, e);
        end
    endtask

    task automatic push(input rec_t r, input string t, input int n);
        for (int i = 0; i < n; i++) begin
            exp_q.push_back(r);
            tag_q.push_back(t);
        end
    endtask

    // Expected cycles for one region, built from R1-style step rules.
    task automatic plan_region(input int tgt, input logic [2:0] cas,
                               input int trc, input logic [14:0] rp);
        rec_t b, c;
        b = '0;
        b.cke = 1'b1; b.cs_n = (tgt == 0) ? 2'b10 : 2'b01;
        b.ras_n = 1'b1; b.cas_n = 1'b1; b.we_n = 1'b1;
        b.ref_period = rp; b.busy = 1'b1;
        push(b, "R2", W_L);
        c = b; c.ras_n = 1'b0; c.we_n = 1'b0; c.addr[10] = 1'b1;
        push(c, "R1", 1);
        push(b, "R3", W_S);
        for (int k = 0; k < NREF; k++) begin
            c = b; c.ras_n = 1'b0; c.cas_n = 1'b0;
            push(c, "R4", 1);
            if (k < NREF - 1 && trc > 1) push(b, "R4", trc - 1);
        end
        push(b, "R3", W_S);
        c = b; c.ras_n = 1'b0; c.cas_n = 1'b0; c.we_n = 1'b0;
        c.addr[6:4] = cas;
        push(c, "R5", 1);
        push(b, "R3", W_S);
        c = b; c.ref_load = 1'b1;
        push(c, "R9", 1);
    endtask

    // Issue a valid start and run to completion, optionally poking start
    // and the configuration inputs mid-run (R11).
    task automatic run_valid(input bit two, input int ta, input int tb,
                             input logic [2:0] cas, input int trc,
                             input logic [13:0] rc, input int poke_at);
        logic [14:0] rp;
        int cyc;
        rp = (rc == 0) ? 15'd16392 : {rc, 1'b0};
        two_banks = two; tgt_first = 2'(ta); tgt_second = 2'(tb);
        cas_lat = cas; t_rc = 4'(trc); ref_count = rc;
        plan_region(ta, cas, trc, rp);
        if (two) plan_region(tb, cas, trc, rp);
        idle_r = '0;
        idle_r.cke = 1'b1; idle_r.cs_n = 2'b11; idle_r.ras_n = 1'b1;
        idle_r.cas_n = 1'b1; idle_r.we_n = 1'b1; idle_r.ref_period = rp;
        idle_r.done = 1'b1; idle_r.en = 1'b1;
        idle_tag = "R8";
        aref_seen = 0;
        start = 1'b1;
        tick();
        start = 1'b0;
        cyc = 1;
        while (exp_q.size() > 0) begin
            if (cyc == poke_at) begin
                start = 1'b1; cas_lat = 3'd6; t_rc = 4'd9;
                ref_count = 14'd5; two_banks = ~two; tgt_first = 2'd3;
            end
            tick();
            start = 1'b0;
            cyc++;
        end
        tick();
        check(aref_seen == (two ? 2 * NREF : NREF), "R4 refresh count",
              64'(aref_seen), 64'(two ? 2 * NREF : NREF));
        check(mrs_addr == {6'd0, cas, 4'd0}, "R5 mode word",
              64'(mrs_addr), 64'({6'd0, cas, 4'd0}));
    endtask

    // Issue a start with an invalid target; nothing but err may change.
    task automatic run_bad(input bit two, input int ta, input int tb);
        two_banks = two; tgt_first = 2'(ta); tgt_second = 2'(tb);
        idle_r.done = 1'b0; idle_r.en = 1'b0; idle_r.err = 1'b1;
        idle_tag = "R10";
        aref_seen = 0;
        start = 1'b1;
        tick();
        start = 1'b0;
        repeat (20) tick();
        check(aref_seen == 0, "R10 no commands", 64'(aref_seen), 64'd0);
    endtask

    initial begin
        idle_r = '0;
        idle_r.cs_n = 2'b11; idle_r.ras_n = 1'b1;
        idle_r.cas_n = 1'b1; idle_r.we_n = 1'b1;
        repeat (3) tick();           // R12 reset state under reset
        rst_n = 1'b1;
        repeat (3) tick();           // R12 reset state after release
        // R1..R5, R9, R11: one region, poke mid-run with other settings.
        run_valid(1'b0, 0, 3, 3'd3, 4, 14'd100, 50);
        // R7, R4 back-to-back, R9 default count: two regions, second first.
        run_valid(1'b1, 1, 0, 3'd2, 1, 14'd0, 700);
        // R10: invalid first target, then invalid second target.
        run_bad(1'b0, 2, 0);
        run_bad(1'b1, 0, 3);
        // R10 recovery and R7 ordering with a one-cycle refresh gap.
        run_valid(1'b1, 0, 1, 3'd7, 2, 14'd4000, -1);
        // R4 with t_rc of zero treated as back to back.
        run_valid(1'b0, 1, 2, 3'd1, 0, 14'd1, -1);
        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule